// File: doc/BRIEF.md
# Performance Monitor Counter Register Bank

This block is a small register file for performance monitoring. It holds one cycle counter and three event counters. Each event counter has its own event selector, which picks one line of an event pulse bus. Software reaches the bank through a plain register port: address, write data, write enable, read strobe and a privilege flag. The event counters and their selectors are not mapped one by one. A single select register chooses which counter pair sits behind two indexed addresses.

A control register enables counting as a whole, enables the cycle counter on its own, and gives two self-clearing reset bits. A user-enable register lets software decide whether non-privileged code may touch the bank. A refused access reads as zero, has no effect, and raises a one-cycle error pulse. Read data is registered. It appears in the cycle after the strobe and is zero in every other cycle.

Top module: `pmu_regbank`

## Requirements
- R1: Address map (3-bit address): 0 control, 1 cycle counter, 2 select, 3 indexed event selector, 4 indexed event counter, 5 user enable. Select values 0, 1 and 2 route addresses 3 and 4 to counter pair 0, 1 and 2.
- R2: The select register keeps wdata[4:0] and reads bits [31:5] as zero. While it holds a value above 2, reads of addresses 3 and 4 return zero and writes to them change nothing.
- R3: The cycle counter adds one on every clock edge while control bit 0 (global enable) and control bit 1 (cycle enable) are both set. It holds otherwise and wraps from all ones to zero.
- R4: A write to the cycle counter loads it only while it is not counting. A write while it counts leaves it on its normal increment.
- R5: Event counter k adds one on each edge where control bit 0 is set and event input bit `esel[k]` is high. It is 32 bits wide and wraps to zero.
- R6: Writing control bit 2 clears the cycle counter, and writing control bit 3 clears all event counters, on the following edge. Both bits then read back as zero.
- R7: A privileged access always goes through. A user access goes through when the user-enable register bit 0 is set.
- R8: A refused user access reads zero, changes no register, and sets the error output for exactly the cycle after the access.
- R9: The user-enable register accepts writes only in privileged mode. A user read of it always succeeds.
- R10: Read data shows the addressed value in the cycle after a read strobe and is zero otherwise. Addresses 6 and 7 read as zero without an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, synchronously released upstream |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write enable, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| priv_i | input | 1 | High for a privileged access |
| evt_i | input | 8 | Event pulse bus, one bit per event source |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle pulse after a refused access |

## Verification
Any internal fault here shows up as a wrong value on the first read of the affected register. That read appears on rdata_o one cycle after its strobe.

- A select register with the wrong content routes the next indexed read to another counter pair, or returns zero where a value was due.
- A counter that misses or repeats an increment carries the error forward. The error stays there until the next load or clear.
- A wrong privilege decision shows on err_o in the very next cycle. A write that should have been refused is exposed by a privileged read-back.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_CYC   = 3'd1,
    REG_SEL   = 3'd2,
    REG_EVSEL = 3'd3,
    REG_EVCNT = 3'd4,
    REG_UEN   = 3'd5
  } reg_addr_e;

  // control register, bit 0 is glb_en
  typedef struct packed {
    logic evt_clr;
    logic cyc_clr;
    logic cyc_en;
    logic glb_en;
  } ctrl_t;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  // clear beats load, load beats increment
  always_comb begin
    cnt_en = clr_i || ld_i || inc_i;
    if (clr_i)     cnt_d = '0;
    else if (ld_i) cnt_d = ld_val_i;
    else           cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pmu_access.sv
module pmu_access
  import pmu_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              priv_i,
  input  logic              uen_i,
  output logic              wr_ok_o,
  output logic              rd_ok_o,
  output logic              deny_o
);
  logic is_uen;

  always_comb begin
    is_uen  = (addr_i == REG_UEN);
    rd_ok_o = rd_en_i && (priv_i || uen_i || is_uen);
    wr_ok_o = wr_en_i && (priv_i || (uen_i && !is_uen));
    deny_o  = (rd_en_i && !rd_ok_o) || (wr_en_i && !wr_ok_o);
  end
endmodule

// File: rtl/pmu_regbank.sv
module pmu_regbank
  import pmu_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CNT = 3,
  parameter int NUM_EVT = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              priv_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  localparam int ESEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic              wr_ok, rd_ok, deny;
  ctrl_t             ctrl_q, ctrl_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              uen_q, uen_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_val;
  logic              err_q;
  logic              wr_ctrl, wr_cyc, wr_sel, wr_esel, wr_ecnt, wr_uen;
  logic              idx_ok, cyc_run, cyc_clr;
  logic [CNT_W-1:0]  cyc_cnt;
  logic [ESEL_W-1:0] esel_all [NUM_CNT];
  logic [CNT_W-1:0]  ecnt_all [NUM_CNT];

  pmu_access u_acc (
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .priv_i  (priv_i),
    .uen_i   (uen_q),
    .wr_ok_o (wr_ok),
    .rd_ok_o (rd_ok),
    .deny_o  (deny)
  );

  always_comb begin
    wr_ctrl = wr_ok && (addr_i == REG_CTRL);
    wr_cyc  = wr_ok && (addr_i == REG_CYC);
    wr_sel  = wr_ok && (addr_i == REG_SEL);
    wr_esel = wr_ok && (addr_i == REG_EVSEL);
    wr_ecnt = wr_ok && (addr_i == REG_EVCNT);
    wr_uen  = wr_ok && (addr_i == REG_UEN);
    idx_ok  = (sel_q < SEL_W'(NUM_CNT));
    cyc_run = ctrl_q.glb_en && ctrl_q.cyc_en;
    cyc_clr = ctrl_q.cyc_clr;
  end

  // next state of the small registers
  always_comb begin
    ctrl_d         = ctrl_q;
    ctrl_d.cyc_clr = 1'b0;
    ctrl_d.evt_clr = 1'b0;
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata_i[3:0]);
    sel_d = wr_sel ? wdata_i[SEL_W-1:0] : sel_q;
    uen_d = wr_uen ? wdata_i[0] : uen_q;
  end

  // read mux
  always_comb begin
    rd_val = '0;
    case (addr_i)
      REG_CTRL: rd_val = DATA_W'(ctrl_q);
      REG_CYC:  rd_val = DATA_W'(cyc_cnt);
      REG_SEL:  rd_val = DATA_W'(sel_q);
      REG_UEN:  rd_val = DATA_W'(uen_q);
      REG_EVSEL: begin
        for (int k = 0; k < NUM_CNT; k++)
          if (idx_ok && (sel_q == SEL_W'(k))) rd_val = DATA_W'(esel_all[k]);
      end
      REG_EVCNT: begin
        for (int k = 0; k < NUM_CNT; k++)
          if (idx_ok && (sel_q == SEL_W'(k))) rd_val = DATA_W'(ecnt_all[k]);
      end
      default: rd_val = '0;
    endcase
    rdata_d = rd_ok ? rd_val : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      sel_q   <= '0;
      uen_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      sel_q   <= sel_d;
      uen_q   <= uen_d;
      rdata_q <= rdata_d;
      err_q   <= deny;
    end
  end

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cyc_clr),
    .ld_i     (wr_cyc && !cyc_run),
    .ld_val_i (wdata_i[CNT_W-1:0]),
    .inc_i    (cyc_run),
    .cnt_o    (cyc_cnt)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_evt
    logic              pick;
    logic [ESEL_W-1:0] esel_q;

    assign pick = idx_ok && (sel_q == SEL_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               esel_q <= '0;
      else if (wr_esel && pick)  esel_q <= wdata_i[ESEL_W-1:0];
    end

    assign esel_all[k] = esel_q;

    pmu_counter #(.W(CNT_W)) u_ecnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (ctrl_q.evt_clr),
      .ld_i     (wr_ecnt && pick),
      .ld_val_i (wdata_i[CNT_W-1:0]),
      .inc_i    (ctrl_q.glb_en && evt_i[esel_q]),
      .cnt_o    (ecnt_all[k])
    );
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pmu_regbank_chk.sv
module pmu_regbank_chk
  import pmu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              priv_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              uen_q,
  input logic              cyc_run,
  input logic              cyc_clr,
  input logic [CNT_W-1:0]  cyc_cnt
);
  p_sel_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && priv_i && addr_i == REG_SEL) |=> rdata_o[DATA_W-1:SEL_W] == '0);

  p_cyc_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_run && !cyc_clr) |=> cyc_cnt == $past(cyc_cnt) + CNT_W'(1));

  p_cyc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_run && !cyc_clr && !(wr_en_i && addr_i == REG_CYC)) |=> $stable(cyc_cnt));

  p_cyc_wr_blocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_run && !cyc_clr && wr_en_i && priv_i && addr_i == REG_CYC)
      |=> cyc_cnt == $past(cyc_cnt) + CNT_W'(1));

  p_cyc_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_clr |=> cyc_cnt == '0);

  p_priv_no_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_i |=> !err_o);

  p_deny_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !priv_i && !uen_q && addr_i != REG_UEN) |=> (err_o && rdata_o == '0));

  p_uen_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == REG_UEN) |=> !err_o);

  p_idle_rdata_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == '0);
endmodule

bind pmu_regbank pmu_regbank_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .priv_i  (priv_i),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .uen_q   (uen_q),
  .cyc_run (cyc_run),
  .cyc_clr (cyc_clr),
  .cyc_cnt (cyc_cnt)
);

// File: tb/pmu_regbank_test.sv
module pmu_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] AC = 3'd0, AY = 3'd1, AS = 3'd2, AE = 3'd3, AN = 3'd4, AU = 3'd5;

  typedef struct packed {
    logic [3:0]  req;
    logic        priv;
    logic        wr;
    logic        rd;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        eerr;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 1'b1, 1'b1, 1'b0, AS, 32'hFFFF_FFE1, 32'h0, 1'b0},  // R2 select=1
    '{4'd2, 1'b1, 1'b0, 1'b1, AS, 32'h0, 32'h1, 1'b0},          // R2 upper bits zero
    '{4'd1, 1'b1, 1'b1, 1'b0, AE, 32'h5, 32'h0, 1'b0},          // R1 esel1=5
    '{4'd1, 1'b1, 1'b1, 1'b0, AS, 32'h0, 32'h0, 1'b0},
    '{4'd1, 1'b1, 1'b1, 1'b0, AE, 32'h2, 32'h0, 1'b0},          // R1 esel0=2
    '{4'd1, 1'b1, 1'b0, 1'b1, AE, 32'h0, 32'h2, 1'b0},
    '{4'd1, 1'b1, 1'b1, 1'b0, AS, 32'h1, 32'h0, 1'b0},
    '{4'd1, 1'b1, 1'b0, 1'b1, AE, 32'h0, 32'h5, 1'b0},
    '{4'd1, 1'b1, 1'b1, 1'b0, AN, 32'h1234, 32'h0, 1'b0},
    '{4'd1, 1'b1, 1'b0, 1'b1, AN, 32'h0, 32'h1234, 1'b0},
    '{4'd2, 1'b1, 1'b1, 1'b0, AS, 32'h7, 32'h0, 1'b0},          // R2 out of range
    '{4'd2, 1'b1, 1'b0, 1'b1, AN, 32'h0, 32'h0, 1'b0},
    '{4'd2, 1'b1, 1'b1, 1'b0, AN, 32'hAAAA, 32'h0, 1'b0},
    '{4'd2, 1'b1, 1'b0, 1'b1, AE, 32'h0, 32'h0, 1'b0},
    '{4'd2, 1'b1, 1'b1, 1'b0, AS, 32'h1, 32'h0, 1'b0},
    '{4'd2, 1'b1, 1'b0, 1'b1, AN, 32'h0, 32'h1234, 1'b0},       // R2 write had no effect
    '{4'd8, 1'b0, 1'b0, 1'b1, AS, 32'h0, 32'h0, 1'b1},          // R8 refused read
    '{4'd8, 1'b0, 1'b1, 1'b0, AN, 32'h9, 32'h0, 1'b1},          // R8 refused write
    '{4'd8, 1'b1, 1'b0, 1'b1, AN, 32'h0, 32'h1234, 1'b0},
    '{4'd9, 1'b0, 1'b0, 1'b1, AU, 32'h0, 32'h0, 1'b0},          // R9 user read ok
    '{4'd9, 1'b0, 1'b1, 1'b0, AU, 32'h1, 32'h0, 1'b1},          // R9 user write refused
    '{4'd9, 1'b1, 1'b0, 1'b1, AU, 32'h0, 32'h0, 1'b0},
    '{4'd10, 1'b1, 1'b0, 1'b1, 3'd6, 32'h0, 32'h0, 1'b0},       // R10 unmapped
    '{4'd9, 1'b1, 1'b1, 1'b0, AU, 32'h1, 32'h0, 1'b0},
    '{4'd7, 1'b0, 1'b0, 1'b1, AS, 32'h0, 32'h1, 1'b0},          // R7 user allowed
    '{4'd7, 1'b0, 1'b1, 1'b0, AS, 32'h2, 32'h0, 1'b0},
    '{4'd7, 1'b0, 1'b0, 1'b1, AS, 32'h0, 32'h2, 1'b0},
    '{4'd9, 1'b0, 1'b0, 1'b1, AU, 32'h0, 32'h1, 1'b0},
    '{4'd9, 1'b1, 1'b1, 1'b0, AU, 32'h0, 32'h0, 1'b0},
    '{4'd3, 1'b1, 1'b0, 1'b1, AY, 32'h0, 32'h0, 1'b0}           // R3 idle counter
  };

  logic        clk, rst_n, wr_en, rd_en, priv, err;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata, got_rd;
  logic [7:0]  evt;
  logic        got_err;
  int          checks, errors;
  bit          done;

  pmu_regbank uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .priv_i(priv), .evt_i(evt),
    .rdata_o(rdata), .err_o(err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // drive at a negedge, consume one posedge, sample at the next negedge
  task automatic bus(input logic p, input logic w, input logic r, input logic [2:0] a,
                     input logic [31:0] d, input logic [7:0] ev);
    priv = p; wr_en = w; rd_en = r; addr = a; wdata = d; evt = ev;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; evt = '0;
    got_rd = rdata; got_err = err;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus(1'b1, 1'b1, 1'b0, a, d, 8'h0);
  endtask

  task automatic rd_chk(input int req, input logic [2:0] a, input logic [31:0] exp, input string what);
    bus(1'b1, 1'b0, 1'b1, a, 32'h0, 8'h0);
    chk(req, got_rd, exp, what);
  endtask

  task automatic idle(input logic [7:0] ev);
    bus(1'b1, 1'b0, 1'b0, 3'd0, 32'h0, ev);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; priv = 1'b1;
    addr = '0; wdata = '0; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(10, rdata, 32'h0, "reset rdata");           // R10
    chk(8, {31'h0, err}, 32'h0, "reset err");       // R8
    rd_chk(6, AC, 32'h0, "reset ctrl");             // R6

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i].priv, VEC[i].wr, VEC[i].rd, VEC[i].addr, VEC[i].wdata, 8'h0);
      chk(int'(VEC[i].req), got_rd, VEC[i].exp, $sformatf("vector %0d data", i));
      chk(int'(VEC[i].req), {31'h0, got_err}, {31'h0, VEC[i].eerr}, $sformatf("vector %0d err", i));
    end

    // R3 / R4: load while stopped, count six edges
    wr(AY, 32'd100);
    wr(AC, 32'h3);
    repeat (5) idle(8'h0);
    wr(AC, 32'h0);
    rd_chk(3, AY, 32'd106, "cycle count");
    // R4: write while running is ignored
    wr(AC, 32'h3);
    wr(AY, 32'd5);
    wr(AC, 32'h0);
    rd_chk(4, AY, 32'd108, "cycle write while running");
    // R3 wrap
    wr(AY, 32'hFFFF_FFFF);
    wr(AC, 32'h3);
    wr(AC, 32'h0);
    rd_chk(3, AY, 32'h0, "cycle wrap");
    // R6 cycle clear
    wr(AY, 32'd50);
    wr(AC, 32'h4);
    idle(8'h0);
    rd_chk(6, AC, 32'h0, "cycle clear bit self-clears");
    rd_chk(6, AY, 32'h0, "cycle cleared");

    // R5 event counting
    wr(AC, 32'h8);
    idle(8'h0);
    idle(8'h25);            // global enable off: no count
    wr(AC, 32'h1);
    idle(8'h04); idle(8'h24); idle(8'h01); idle(8'h20); idle(8'h25); idle(8'h04);
    wr(AC, 32'h0);
    wr(AS, 32'h0); rd_chk(5, AN, 32'd4, "event counter 0");
    wr(AS, 32'h1); rd_chk(5, AN, 32'd3, "event counter 1");
    wr(AS, 32'h2); rd_chk(5, AN, 32'd2, "event counter 2");
    // R5 wrap
    wr(AN, 32'hFFFF_FFFF);
    wr(AC, 32'h1);
    idle(8'h01);
    wr(AC, 32'h0);
    rd_chk(5, AN, 32'h0, "event wrap");
    // R6 event clear
    wr(AC, 32'h8);
    idle(8'h0);
    rd_chk(6, AC, 32'h0, "event clear bit self-clears");
    wr(AS, 32'h0);
    rd_chk(6, AN, 32'h0, "event counter cleared");

    // R8 error lasts one cycle; R10 idle rdata is zero
    bus(1'b0, 1'b0, 1'b1, AS, 32'h0, 8'h0);
    chk(8, {31'h0, got_err}, 32'h1, "refused read error");
    idle(8'h0);
    chk(8, {31'h0, got_err}, 32'h0, "error pulse ends");
    rd_chk(1, AE, 32'h2, "selector 0 kept");
    idle(8'h0);
    chk(10, got_rd, 32'h0, "rdata zero without strobe");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule